// File: doc/BRIEF.md
# Nibble-wide serial PSRAM access controller

This block sits between a CPU core's memory port and a 4-bit serial pseudo-static RAM. The core asks for one byte or one 16-bit word at a 24-bit byte address. The controller turns each request into a framed transaction on the device pins: chip-enable low, a command byte, the address, an optional read wait, the data nibbles, then chip-enable high. A single-cycle done pulse reports completion and carries read data.

After reset the controller holds the device idle for a settling interval, 150 µs at the design clock by default. It then switches the device into four-line mode by shifting one command serially on data line 0. From then on every phase runs four bits per serial clock. The serial clock runs at half the controller clock. A word whose two bytes lie in different 1 KiB pages is carried out as two byte transactions, and the core sees only one completion. Read data can be captured up to seven controller clocks after the serial clock edge that launched it, so board delay can be absorbed.

Top module: `qpsram_ctrl`

## Requirements
- R1: During reset and for at least POR_CYCLES controller clocks after reset is released, chip-enable stays high and req_ready stays low.
- R2: The first frame after the settling wait shifts command 0x35 serially, most significant bit first, on data line 0 with only line 0 enabled (psram_dq_oe = 4'b0001). After this frame the device operates in four-line mode.
- R3: A read frame starts with command 0xEB and then the 24-bit address, as 8 nibbles on all four lines (psram_dq_oe = 4'hF). Each byte's high nibble goes first, and the address goes most significant byte first.
- R4: A read leaves WAIT_CLKS (10) serial clocks after the last address nibble with the data lines released (psram_dq_oe = 0). The lines stay released through the read data phase.
- R5: A write frame starts with command 0x02 and the address as 8 nibbles. The first data nibble follows on the very next serial clock, with no wait.
- R6: A byte moves as 2 nibbles and a word as 4. The byte at the request address travels first and maps to data bits [7:0]. The byte at address+1 maps to bits [15:8]. A byte read returns its value in rsp_rdata[7:0] with [15:8] zero.
- R7: A word request whose address has bits [9:0] = 0x3FF is split into a byte transaction at the address and a byte transaction at address+1. It gives one done pulse and the same data as an unsplit word.
- R8: Chip-enable returns high when the data phase ends and is high when rsp_done is seen. The serial clock is low whenever chip-enable is high.
- R9: A request is taken on the clock where req_valid and req_ready are both high. req_ready is low from the next cycle until that request's done. Every request gets exactly one single-cycle rsp_done, in order.
- R10: The serial clock is never high for two controller clocks in a row. Outgoing data changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data, byte at address in [7:0] |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| psram_ce_n | output | 1 | Device chip-enable, active low |
| psram_sclk | output | 1 | Device serial clock |
| psram_dq_o | output | 4 | Data lines, outgoing value |
| psram_dq_oe | output | 4 | Per-line output enable |
| psram_dq_i | input | 4 | Data lines, incoming value |

## Verification
Two functions can fall in the same cycle. First, the done pulse of one request coincides with req_ready rising, so a request already held valid is accepted on the next edge. The bench provokes this by issuing every request back to back from a driver task. A queue-based scoreboard then has to see completions in order, one per request, with chip-enable already high. Second, on page-crossing words the end of the first byte transaction coincides with the start of the second. Random addresses clustered at page ends exercise this, and a behavioural four-line device model in the bench judges it: the model stores written bytes by address and returns them on reads, so any lost or misplaced byte shows up as a miscompare.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;
  localparam int unsigned ADDR_W = 24;

  localparam logic [7:0] CMD_QUAD_ON = 8'h35;
  localparam logic [7:0] CMD_RD      = 8'hEB;
  localparam logic [7:0] CMD_WR      = 8'h02;

  typedef enum logic [2:0] {
    X_BOOT, X_QON, X_IDLE, X_HDR, X_WAIT, X_RDAT, X_WDAT, X_DRAIN
  } xfer_st_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE1, S_WAIT1, S_ISSUE2, S_WAIT2
  } split_st_t;
endpackage

// File: rtl/qpsram_por.sv
module qpsram_por #(
  parameter int unsigned CYCLES = 18750
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(CYCLES)) done <= 1'b1;
      else                    cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qpsram_xfer.sv
module qpsram_xfer
  import qpsram_pkg::*;
#(
  parameter int unsigned WAIT_CLKS  = 10,
  parameter int unsigned SAMPLE_DLY = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_ok,
  input  logic              op_start,
  input  logic              op_rd,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_two,
  input  logic [15:0]       op_wdata,
  output logic              op_ready,
  output logic              op_end,
  output logic [15:0]       op_rdata,
  output logic              ce_n,
  output logic              sclk,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_i
);
  localparam int unsigned CMAX  = (WAIT_CLKS > 8) ? WAIT_CLKS : 8;
  localparam int unsigned CNT_W = $clog2(CMAX + 1);

  xfer_st_t          st;
  logic              h;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        dcnt;
  logic [31:0]       sh;
  logic [15:0]       wsh, rsh;
  logic              two_q, rd_q;
  logic              stb, cap;
  logic [CNT_W-1:0]  last_nib;

  assign stb      = (st == X_RDAT) && !h;
  assign last_nib = two_q ? CNT_W'(3) : CNT_W'(1);
  assign op_ready = (st == X_IDLE);
  assign op_rdata = two_q ? {rsh[7:0], rsh[15:8]} : {8'h00, rsh[7:0]};

  generate
    if (SAMPLE_DLY == 0) begin : g_nodly
      assign cap = stb;
    end else begin : g_dly
      logic [SAMPLE_DLY-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= (pipe << 1) | SAMPLE_DLY'(stb);
      end
      assign cap = pipe[SAMPLE_DLY-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= X_BOOT; h <= 1'b0; cnt <= '0; dcnt <= '0;
      sh <= '0; wsh <= '0; rsh <= '0; two_q <= 1'b0; rd_q <= 1'b0;
      ce_n <= 1'b1; sclk <= 1'b0; dq_o <= '0; dq_oe <= '0; op_end <= 1'b0;
    end else begin
      op_end <= 1'b0;
      if (cap) rsh <= {rsh[11:0], dq_i};
      case (st)
        X_BOOT: if (boot_ok) begin
          ce_n <= 1'b0; dq_oe <= 4'b0001; h <= 1'b0; cnt <= '0;
          sh <= {CMD_QUAD_ON, 24'h0}; dq_o <= {3'b000, CMD_QUAD_ON[7]};
          st <= X_QON;
        end
        X_IDLE: if (op_start) begin
          ce_n <= 1'b0; dq_oe <= 4'hF; h <= 1'b0; cnt <= '0;
          sh <= {(op_rd ? CMD_RD : CMD_WR), op_addr};
          dq_o <= op_rd ? CMD_RD[7:4] : CMD_WR[7:4];
          wsh <= op_two ? {op_wdata[7:0], op_wdata[15:8]} : {op_wdata[7:0], 8'h00};
          two_q <= op_two; rd_q <= op_rd;
          st <= X_HDR;
        end
        X_DRAIN: begin
          if (dcnt == 3'(SAMPLE_DLY)) begin
            ce_n <= 1'b1; dq_oe <= '0; op_end <= 1'b1; st <= X_IDLE;
          end else dcnt <= dcnt + 1'b1;
        end
        default: begin
          if (!h) begin
            sclk <= 1'b1; h <= 1'b1;
          end else begin
            sclk <= 1'b0; h <= 1'b0;
            case (st)
              X_QON: if (cnt == CNT_W'(7)) begin
                ce_n <= 1'b1; dq_oe <= '0; st <= X_IDLE;
              end else begin
                cnt <= cnt + 1'b1; sh <= sh << 1; dq_o <= {3'b000, sh[30]};
              end
              X_HDR: if (cnt == CNT_W'(7)) begin
                cnt <= '0;
                if (rd_q) begin
                  dq_oe <= '0; st <= X_WAIT;
                end else begin
                  dq_o <= wsh[15:12]; wsh <= wsh << 4; st <= X_WDAT;
                end
              end else begin
                cnt <= cnt + 1'b1; dq_o <= sh[27:24]; sh <= sh << 4;
              end
              X_WAIT: if (cnt == CNT_W'(WAIT_CLKS - 1)) begin
                cnt <= '0; st <= X_RDAT;
              end else cnt <= cnt + 1'b1;
              X_WDAT: if (cnt == last_nib) begin
                ce_n <= 1'b1; dq_oe <= '0; op_end <= 1'b1; st <= X_IDLE;
              end else begin
                cnt <= cnt + 1'b1; dq_o <= wsh[15:12]; wsh <= wsh << 4;
              end
              X_RDAT: if (cnt == last_nib) begin
                if (SAMPLE_DLY <= 1) begin
                  ce_n <= 1'b1; op_end <= 1'b1; st <= X_IDLE;
                end else begin
                  dcnt <= 3'd2; st <= X_DRAIN;
                end
              end else cnt <= cnt + 1'b1;
              default: st <= X_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R1
  boot_hold_chk: assert property (@(posedge clk) disable iff (rst) !boot_ok |-> ce_n);
  // R8
  ce_idle_clk_chk: assert property (@(posedge clk) disable iff (rst) ce_n |-> !sclk);
  // R10
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (rst) sclk |=> !sclk);
  // R10
  data_on_low_chk: assert property (@(posedge clk) disable iff (rst) !$stable(dq_o) |-> !sclk);
  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (rst) cap |-> (dq_oe == 4'h0));
endmodule

// File: rtl/qpsram_split.sv
module qpsram_split
  import qpsram_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  input  logic              op_ready,
  output logic              op_start,
  output logic              op_rd,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_two,
  output logic [15:0]       op_wdata,
  input  logic              op_end,
  input  logic [15:0]       op_rdata
);
  localparam int unsigned PG_W = $clog2(PAGE_BYTES);

  split_st_t         st;
  logic              wr_q, word_q, cross_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wd_q;
  logic              accept;

  assign req_ready = (st == S_IDLE) && op_ready;
  assign accept    = req_valid && req_ready;
  assign op_start  = (st == S_ISSUE1) || (st == S_ISSUE2);
  assign op_rd     = !wr_q;
  assign op_addr   = (st == S_ISSUE2) ? addr_q + ADDR_W'(1) : addr_q;
  assign op_two    = word_q && !cross_q;
  assign op_wdata  = (st == S_ISSUE2) ? {8'h00, wd_q[15:8]} : wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; wr_q <= 1'b0; word_q <= 1'b0; cross_q <= 1'b0;
      addr_q <= '0; wd_q <= '0; rsp_done <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          wr_q <= req_write; word_q <= req_word; addr_q <= req_addr; wd_q <= req_wdata;
          cross_q <= req_word && (req_addr[PG_W-1:0] == {PG_W{1'b1}});
          st <= S_ISSUE1;
        end
        S_ISSUE1: st <= S_WAIT1;
        S_WAIT1: if (op_end) begin
          if (cross_q) begin
            if (!wr_q) rsp_rdata[7:0] <= op_rdata[7:0];
            st <= S_ISSUE2;
          end else begin
            if (!wr_q) rsp_rdata <= op_rdata;
            rsp_done <= 1'b1; st <= S_IDLE;
          end
        end
        S_ISSUE2: st <= S_WAIT2;
        S_WAIT2: if (op_end) begin
          if (!wr_q) rsp_rdata[15:8] <= op_rdata[7:0];
          rsp_done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  accept_ready_chk: assert property (@(posedge clk) disable iff (rst) accept |=> !req_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done);
  // R7
  second_half_chk: assert property (@(posedge clk) disable iff (rst) (st == S_ISSUE2) |-> (op_ready && !op_two));
endmodule

// File: rtl/qpsram_ctrl.sv
module qpsram_ctrl
  import qpsram_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 18750,
  parameter int unsigned WAIT_CLKS  = 10,
  parameter int unsigned SAMPLE_DLY = 0,
  parameter int unsigned PAGE_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic        req_word,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        psram_ce_n,
  output logic        psram_sclk,
  output logic [3:0]  psram_dq_o,
  output logic [3:0]  psram_dq_oe,
  input  logic [3:0]  psram_dq_i
);
  logic              boot_ok;
  logic              op_ready, op_start, op_rd, op_two, op_end;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_wdata, op_rdata;

  qpsram_por #(.CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .done(boot_ok)
  );

  qpsram_split #(.PAGE_BYTES(PAGE_BYTES)) u_split (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .op_ready(op_ready), .op_start(op_start), .op_rd(op_rd), .op_addr(op_addr),
    .op_two(op_two), .op_wdata(op_wdata), .op_end(op_end), .op_rdata(op_rdata)
  );

  qpsram_xfer #(.WAIT_CLKS(WAIT_CLKS), .SAMPLE_DLY(SAMPLE_DLY)) u_xfer (
    .clk(clk), .rst(rst), .boot_ok(boot_ok),
    .op_start(op_start), .op_rd(op_rd), .op_addr(op_addr), .op_two(op_two),
    .op_wdata(op_wdata), .op_ready(op_ready), .op_end(op_end), .op_rdata(op_rdata),
    .ce_n(psram_ce_n), .sclk(psram_sclk), .dq_o(psram_dq_o), .dq_oe(psram_dq_oe),
    .dq_i(psram_dq_i)
  );
endmodule

// File: tb/qpsram_ctrl_bench.sv
module qpsram_ctrl_bench;
  localparam int POR  = 300;
  localparam int WAIT = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        psram_ce_n, psram_sclk;
  logic [3:0]  psram_dq_o, psram_dq_oe;
  logic [3:0]  psram_dq_i = 4'h0;

  qpsram_ctrl #(.POR_CYCLES(POR)) u_qpsram_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .psram_ce_n(psram_ce_n), .psram_sclk(psram_sclk),
    .psram_dq_o(psram_dq_o), .psram_dq_oe(psram_dq_oe), .psram_dq_i(psram_dq_i)
  );

  int checks = 0, fails = 0, cyc = 0, rel_cyc = 0, first_ce = -1;
  int err_hdr = 0, err_wait = 0, err_edge = 0, quad_frames = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural four-line device ----------------
  logic [7:0] dev_mem [logic [23:0]];
  logic [7:0] shadow  [logic [23:0]];

  function automatic logic [7:0] dev_rd(input logic [23:0] a);
    return dev_mem.exists(a) ? dev_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] sh_rd(input logic [23:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  logic        quad = 1'b0;
  int          n = 0, sbits = 0;
  logic [7:0]  sbyte = '0, wbyte = '0;
  logic [31:0] hdr = '0;
  logic [3:0]  fall_dq = '0;

  initial begin : dev_model
    logic pce, psc;
    pce = 1'b1; psc = 1'b0;
    forever begin
      @(psram_ce_n or psram_sclk);
      if (pce && !psram_ce_n) begin
        n = 0; sbits = 0; hdr = '0;
        if (first_ce < 0) first_ce = cyc;
        fall_dq = psram_dq_o;
      end
      if (!psc && psram_sclk && !psram_ce_n) begin
        if (psram_dq_o != fall_dq) err_edge++;            // R10
        if (!quad) begin
          sbyte = {sbyte[6:0], psram_dq_o[0]};
          sbits++;
          if (sbits == 8) begin
            chk(sbyte == 8'h35 && psram_dq_oe == 4'b0001, "R2 quad entry",
                {20'h0, psram_dq_oe, sbyte}, {20'h0, 4'b0001, 8'h35});
            quad = (sbyte == 8'h35);
          end
        end else begin
          n++;
          if (n <= 8) begin
            hdr = {hdr[27:0], psram_dq_o};
            if (psram_dq_oe != 4'hF) err_hdr++;            // R3
            if (n == 8) quad_frames++;
          end else if (hdr[31:24] == 8'h02) begin
            int k;
            k = n - 9;
            if (k % 2 == 0) wbyte[7:4] = psram_dq_o;
            else begin
              wbyte[3:0] = psram_dq_o;
              dev_mem[hdr[23:0] + 24'(k / 2)] = wbyte;
            end
          end else if (psram_dq_oe != 4'h0) err_wait++;    // R4
        end
      end
      if (psc && !psram_sclk) begin
        fall_dq = psram_dq_o;
        if (!psram_ce_n && quad && hdr[31:24] == 8'hEB && n >= 8 + WAIT) begin
          int k;
          logic [7:0] b;
          k = n - (8 + WAIT);
          b = dev_rd(hdr[23:0] + 24'(k / 2));
          psram_dq_i = (k % 2 == 0) ? b[7:4] : b[3:0];
        end
      end
      pce = psram_ce_n; psc = psram_sclk;
    end
  end

  // ---------------- scoreboard ----------------
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
      else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[16]) chk(rsp_rdata == e[15:0], t, {16'h0, rsp_rdata}, {16'h0, e[15:0]});
        else       chk(1'b1, "R9 write done", 32'd0, 32'd0);
        chk(psram_ce_n == 1'b1, "R8 ce high at done", {31'h0, psram_ce_n}, 32'd1);
      end
    end
  end

  task automatic issue(input logic wr, input logic [23:0] a, input logic wd,
                       input logic [15:0] d, input string tag);
    logic [15:0] e;
    e = '0;
    if (wr) begin
      shadow[a] = d[7:0];
      if (wd) shadow[a + 24'd1] = d[15:8];
    end else begin
      e = wd ? {sh_rd(a + 24'd1), sh_rd(a)} : {8'h00, sh_rd(a)};
    end
    exp_q.push_back({!wr, e});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_word = wd; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low after accept", {31'h0, req_ready}, 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R9 watchdog expired, outstanding=%0d expected 0", exp_q.size());
      summary();
      $finish;
    end
  end

  initial begin : main
    int wait_cyc;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b0, "R1 ready in reset", {31'h0, req_ready}, 32'd0);
    chk(psram_ce_n == 1'b1, "R1 ce in reset", {31'h0, psram_ce_n}, 32'd1);
    chk(rsp_done == 1'b0, "R9 no done in reset", {31'h0, rsp_done}, 32'd0);
    rst = 1'b0;
    rel_cyc = cyc;
    wait_cyc = 0;
    while (!req_ready && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
    chk(first_ce - rel_cyc >= POR, "R1 settling wait", 32'(first_ce - rel_cyc), 32'(POR));
    chk(quad == 1'b1, "R2 device in quad mode", {31'h0, quad}, 32'd1);

    // directed byte and word traffic
    issue(1'b1, 24'h000010, 1'b0, 16'h00A5, "R5");
    issue(1'b0, 24'h000010, 1'b0, 16'h0000, "R5 byte readback");
    issue(1'b1, 24'h000100, 1'b1, 16'hBEEF, "R5");
    issue(1'b0, 24'h000100, 1'b1, 16'h0000, "R3 word readback");
    issue(1'b0, 24'h000100, 1'b0, 16'h0000, "R6 low byte");
    issue(1'b0, 24'h000101, 1'b0, 16'h0000, "R6 high byte");
    issue(1'b0, 24'hABCDEF, 1'b1, 16'h0000, "R3 unwritten word");

    // page-crossing words
    issue(1'b1, 24'h0003FF, 1'b1, 16'h1234, "R7");
    issue(1'b0, 24'h0003FF, 1'b0, 16'h0000, "R7 byte below page end");
    issue(1'b0, 24'h000400, 1'b0, 16'h0000, "R7 byte in next page");
    issue(1'b0, 24'h0003FF, 1'b1, 16'h0000, "R7 split word read");
    issue(1'b1, 24'hFFFBFF, 0, 16'h00C3, "R7");
    issue(1'b1, 24'hFFFC00, 0, 16'h003C, "R7");
    issue(1'b0, 24'hFFFBFF, 1'b1, 16'h0000, "R7 word over written bytes");
    issue(1'b0, 24'h0007FE, 1'b1, 16'h0000, "R6 word at page end not split");

    // random mix clustered near page ends
    for (int i = 0; i < 160; i++) begin
      logic [23:0] a;
      logic wr, wd;
      int off;
      off = ($urandom_range(0, 1) == 1) ? $urandom_range(1020, 1023) : $urandom_range(0, 15);
      a   = {8'h5A, 16'($urandom_range(0, 7) * 1024 + off)};
      wr  = ($urandom_range(0, 2) == 0);
      wd  = ($urandom_range(0, 1) == 1);
      issue(wr, a, wd, 16'($urandom),
            (wd && a[9:0] == 10'h3FF) ? "R7 random" : "R6 random");
    end

    wait_cyc = 0;
    while (exp_q.size() != 0 && wait_cyc < 2000) begin @(negedge clk); wait_cyc++; end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all requests completed", 32'(exp_q.size()), 32'd0);
    chk(err_hdr == 0, "R3 lines driven in header", 32'(err_hdr), 32'd0);
    chk(err_wait == 0, "R4 lines released in wait and data", 32'(err_wait), 32'd0);
    chk(err_edge == 0, "R10 data steady over rising edge", 32'(err_edge), 32'd0);
    chk(quad_frames > 0, "R3 quad frames seen", 32'(quad_frames), 32'd1);
    summary();
    $finish;
  end
endmodule